// File: doc/BRIEF.md
# Tracking Reference Ramp Sequencer

This block produces the digital reference code that a converter's control loop regulates to. When the converter is switched on, the reference climbs from zero to the programmed target. When it is switched off, or when a fault asks for shutdown, the reference descends back to zero. Movement happens only on pulses taken from a shared synchronisation clock. The rising and falling rates are fixed and unequal, and the fall is five times steeper than the rise. Because every converter on the same sync line counts the same pulses with the same step sizes, their outputs rise and fall together without any data link between them.

A divider qualifies every `TICK_DIV`-th sync pulse. On each qualified pulse the reference moves one step toward its goal, and the last step is trimmed so that the code lands exactly on the goal. The goal is the clamped target while the block is enabled and no fault stop is requested, and zero otherwise. Two registered flags report whether a ramp is in progress and whether the reference sits on the programmed target. With the default constants (10 mV per code, 500 kHz sync, 50 pulses per step), the rise is 0.1 V/ms and a full descent from 5.5 V takes 11 ms.

Top module: `trk_ramp_seq`

## Requirements
- R1: While `rst_n` is low, and at the first sample after reset, `level` is 0 and `ramping` and `on_target` are 0.
- R2: On a qualified tick with `level` below the goal, `level` rises by `UP_STEP` (1 code by default). A step that would pass the goal ends exactly on the goal.
- R3: On a qualified tick with `level` above the goal, `level` falls by `DN_STEP` (5 codes by default). A step that would pass the goal, including zero, ends exactly on the goal.
- R4: After `enable` rises, the first qualified tick already moves `level`. There is no extra start delay.
- R5: A qualified tick is every `TICK_DIV`-th cycle in which `sync_tick` is high, counting from reset. Sync pulses in between leave `level` unchanged.
- R6: The effective target is `target` clamped into [`MIN_CODE`, `MAX_CODE`] (50 and 550 by default). A target below `MIN_CODE`, including 0 (untrimmed), becomes `MIN_CODE`.
- R7: The goal is 0 whenever `enable` is low or `fault_stop` is high. `fault_stop` overrides `enable`.
- R8: A goal change in the middle of a ramp reverses direction from the current `level` on the next qualified tick.
- R9: `ramping` is 1 when the registered `level` differs from the goal. `on_target` is 1 only when `level` equals the effective target while `enable` is high and `fault_stop` is low. Both flags are computed from the inputs present at the same clock edge that loads `level`, and they are never 1 together.
- R10: In a cycle without a qualified tick, `level` keeps its value whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Turn-on request; high ramps toward the target |
| fault_stop | input | 1 | Shutdown request from fault handling; forces the goal to zero |
| target | input | CODE_W | Programmed setpoint code before clamping |
| sync_tick | input | 1 | One-cycle pulse per period of the shared sync clock |
| level | output | CODE_W | Reference code delivered to the control loop |
| ramping | output | 1 | Reference is still moving toward the goal |
| on_target | output | 1 | Reference equals the clamped target while enabled |

## Verification
Some properties are checked by assertions on every cycle. The reference never moves more than one rise step or one fall step per cycle, and it never moves in a cycle that lacks a qualified tick. It never exceeds the top of the clamp range, and the two flags are never high together. With a divider, qualified ticks are never back to back. The bench scenarios cover the properties that depend on sequences of inputs: clamping at both ends of the target range, exact landing on an odd target, the zero goal forced by a fault stop, reversal mid-ramp, and divider phase across single sync pulses.

// File: rtl/trk_pkg.sv
package trk_pkg;

    // Direction chosen by the step unit for the current cycle
    typedef enum logic [1:0] {
        DIR_HOLD = 2'd0,
        DIR_UP   = 2'd1,
        DIR_DOWN = 2'd2
    } trk_dir_e;

endpackage

// File: rtl/trk_tick_div.sv
module trk_tick_div #(
    parameter int TICK_DIV = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_tick,
    output logic qual_tick
);
    localparam int CNT_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TICK_DIV - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        qual_tick = sync_tick && (cnt_q == LAST);
        cnt_d     = cnt_q;
        if (sync_tick) begin
            cnt_d = qual_tick ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    generate
        if (TICK_DIV > 1) begin : g_spacing
            // R5: with a divider, two qualified ticks never fall in consecutive cycles
            a_r5_qual_spacing: assert property (@(posedge clk) disable iff (!rst_n)
                qual_tick |=> !qual_tick);
        end
    endgenerate

    // R5: the phase counter stays below the divide ratio
    a_r5_count_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

endmodule

// File: rtl/trk_goal_sel.sv
module trk_goal_sel #(
    parameter int CODE_W   = 10,
    parameter int MIN_CODE = 50,
    parameter int MAX_CODE = 550
) (
    input  logic              enable,
    input  logic              fault_stop,
    input  logic [CODE_W-1:0] target,
    output logic [CODE_W-1:0] goal,
    output logic              raise
);
    localparam logic [CODE_W-1:0] LO = CODE_W'(MIN_CODE);
    localparam logic [CODE_W-1:0] HI = CODE_W'(MAX_CODE);

    logic [CODE_W-1:0] clamped;

    always_comb begin
        if (target < LO)      clamped = LO;
        else if (target > HI) clamped = HI;
        else                  clamped = target;
        raise = enable && !fault_stop;
        goal  = raise ? clamped : '0;
    end

endmodule

// File: rtl/trk_step_unit.sv
module trk_step_unit
    import trk_pkg::*;
#(
    parameter int CODE_W  = 10,
    parameter int UP_STEP = 1,
    parameter int DN_STEP = 5
) (
    input  logic [CODE_W-1:0] cur,
    input  logic [CODE_W-1:0] goal,
    output logic [CODE_W-1:0] nxt
);
    localparam logic [CODE_W-1:0] UP = CODE_W'(UP_STEP);
    localparam logic [CODE_W-1:0] DN = CODE_W'(DN_STEP);

    trk_dir_e          dir;
    logic [CODE_W-1:0] gap;

    always_comb begin
        if (cur < goal)      dir = DIR_UP;
        else if (cur > goal) dir = DIR_DOWN;
        else                 dir = DIR_HOLD;

        gap = (dir == DIR_UP) ? goal - cur : cur - goal;

        unique case (dir)
            DIR_UP:   nxt = (gap > UP) ? cur + UP : goal;
            DIR_DOWN: nxt = (gap > DN) ? cur - DN : goal;
            default:  nxt = cur;
        endcase
    end

endmodule

// File: rtl/trk_ramp_seq.sv
module trk_ramp_seq #(
    parameter int CODE_W   = 10,
    parameter int MIN_CODE = 50,
    parameter int MAX_CODE = 550,
    parameter int UP_STEP  = 1,
    parameter int DN_STEP  = 5,
    parameter int TICK_DIV = 50
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              fault_stop,
    input  logic [CODE_W-1:0] target,
    input  logic              sync_tick,
    output logic [CODE_W-1:0] level,
    output logic              ramping,
    output logic              on_target
);
    typedef struct packed {
        logic [CODE_W-1:0] lvl;
        logic              busy;
        logic              hit;
    } seq_state_t;

    localparam seq_state_t RST_STATE = '{lvl: '0, busy: 1'b0, hit: 1'b0};

    seq_state_t        st_d, st_q;
    logic              qual_tick;
    logic [CODE_W-1:0] goal;
    logic              raise;
    logic [CODE_W-1:0] step_nxt;

    trk_tick_div #(.TICK_DIV(TICK_DIV)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .sync_tick (sync_tick),
        .qual_tick (qual_tick)
    );

    trk_goal_sel #(.CODE_W(CODE_W), .MIN_CODE(MIN_CODE), .MAX_CODE(MAX_CODE)) u_goal (
        .enable     (enable),
        .fault_stop (fault_stop),
        .target     (target),
        .goal       (goal),
        .raise      (raise)
    );

    trk_step_unit #(.CODE_W(CODE_W), .UP_STEP(UP_STEP), .DN_STEP(DN_STEP)) u_step (
        .cur  (st_q.lvl),
        .goal (goal),
        .nxt  (step_nxt)
    );

    always_comb begin
        st_d      = st_q;
        st_d.lvl  = qual_tick ? step_nxt : st_q.lvl;
        st_d.busy = (st_d.lvl != goal);
        st_d.hit  = raise && (st_d.lvl == goal);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RST_STATE;
        else        st_q <= st_d;
    end

    assign level     = st_q.lvl;
    assign ramping   = st_q.busy;
    assign on_target = st_q.hit;

    // R2: an upward move never exceeds one rise step
    a_r2_rise_step: assert property (@(posedge clk) disable iff (!rst_n)
        (level > $past(level)) |-> ((level - $past(level)) <= CODE_W'(UP_STEP)));

    // R3: a downward move never exceeds one fall step
    a_r3_fall_step: assert property (@(posedge clk) disable iff (!rst_n)
        (level < $past(level)) |-> (($past(level) - level) <= CODE_W'(DN_STEP)));

    // R10: without a qualified tick the reference stays put
    a_r10_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !qual_tick |=> $stable(level));

    // R9: the two flags are mutually exclusive
    a_r9_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(ramping && on_target));

    // R9: being on target implies a code inside the clamp range
    a_r9_hit_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        on_target |-> (level >= CODE_W'(MIN_CODE)));

    // R6: the reference never exceeds the top of the clamp range
    a_r6_level_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
        level <= CODE_W'(MAX_CODE));

endmodule

// File: tb/trk_ramp_seq_bench.sv
module trk_ramp_seq_bench;

    localparam int CW = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          enable = 1'b0;
    logic          fault_stop = 1'b0;
    logic [CW-1:0] target = '0;
    logic          sync_tick = 1'b0;
    logic [CW-1:0] level;
    logic          ramping;
    logic          on_target;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    trk_ramp_seq #(
        .CODE_W(CW), .MIN_CODE(50), .MAX_CODE(550),
        .UP_STEP(1), .DN_STEP(5), .TICK_DIV(2)
    ) u_trk_ramp_seq (
        .clk(clk), .rst_n(rst_n), .enable(enable), .fault_stop(fault_stop),
        .target(target), .sync_tick(sync_tick),
        .level(level), .ramping(ramping), .on_target(on_target)
    );

    typedef struct packed {
        logic [3:0]    req;
        logic          en;
        logic          flt;
        logic [CW-1:0] tgt;
        logic [11:0]   ticks;
        logic [CW-1:0] e_lvl;
        logic          e_busy;
        logic          e_hit;
    } vec_t;

    localparam int NV = 13;
    // Tick counts are even, so the divide-by-2 phase is zero at each vector start
    localparam vec_t VECS [NV] = '{
        '{4'd6,  1'b1, 1'b0, 10'd20,  12'd20,   10'd10,  1'b1, 1'b0}, // R6 low target, R2 rise
        '{4'd6,  1'b1, 1'b0, 10'd20,  12'd80,   10'd50,  1'b0, 1'b1}, // R6 lands on MIN
        '{4'd2,  1'b1, 1'b0, 10'd60,  12'd30,   10'd60,  1'b0, 1'b1}, // R2 exact clamp
        '{4'd3,  1'b0, 1'b0, 10'd60,  12'd4,    10'd50,  1'b1, 1'b0}, // R3 fall by 5
        '{4'd7,  1'b0, 1'b0, 10'd60,  12'd20,   10'd0,   1'b0, 1'b0}, // R7 goal zero
        '{4'd6,  1'b1, 1'b0, 10'd700, 12'd1200, 10'd550, 1'b0, 1'b1}, // R6 clamp MAX
        '{4'd7,  1'b1, 1'b1, 10'd700, 12'd10,   10'd525, 1'b1, 1'b0}, // R7 fault overrides
        '{4'd8,  1'b1, 1'b0, 10'd700, 12'd10,   10'd530, 1'b1, 1'b0}, // R8 reversal
        '{4'd2,  1'b1, 1'b0, 10'd533, 12'd20,   10'd533, 1'b0, 1'b1}, // R2 odd target
        '{4'd3,  1'b0, 1'b0, 10'd533, 12'd214,  10'd0,   1'b0, 1'b0}, // R3 clamp at 0
        '{4'd10, 1'b1, 1'b0, 10'd300, 12'd0,    10'd0,   1'b1, 1'b0}, // R10 no tick
        '{4'd4,  1'b1, 1'b0, 10'd300, 12'd2,    10'd1,   1'b1, 1'b0}, // R4 first step
        '{4'd2,  1'b1, 1'b0, 10'd300, 12'd20,   10'd11,  1'b1, 1'b0}  // R2 continued
    };

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic pulse_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            sync_tick = 1'b1;
            @(negedge clk);
        end
        sync_tick = 1'b0;
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        for (int c = 0; c < 100000; c++) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1", "level in reset", int'(level), 0);
        check("R1", "ramping in reset", int'(ramping), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "level after reset", int'(level), 0);
        check("R1", "on_target after reset", int'(on_target), 0);

        for (int v = 0; v < NV; v++) begin
            string tag;
            tag = $sformatf("R%0d", VECS[v].req);
            enable     = VECS[v].en;
            fault_stop = VECS[v].flt;
            target     = VECS[v].tgt;
            pulse_ticks(int'(VECS[v].ticks));
            check(tag, $sformatf("vec %0d level", v), int'(level), int'(VECS[v].e_lvl));
            check(tag, $sformatf("vec %0d ramping", v), int'(ramping), int'(VECS[v].e_busy));
            check(tag, $sformatf("vec %0d on_target", v), int'(on_target), int'(VECS[v].e_hit));
        end

        // R5: a single sync pulse is only half of the divide ratio
        pulse_ticks(1);
        check("R5", "one pulse no move", int'(level), 11);
        pulse_ticks(1);
        check("R5", "second pulse moves", int'(level), 12);

        // R10: toggling target and enable with no sync pulse leaves level alone
        target = 10'd90;
        enable = 1'b0;
        repeat (5) @(negedge clk);
        check("R10", "no tick hold", int'(level), 12);
        enable = 1'b1;

        // R1: reset in the middle of a ramp clears everything
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", "mid-ramp reset level", int'(level), 0);
        check("R1", "mid-ramp reset ramping", int'(ramping), 0);
        rst_n = 1'b1;
        @(negedge clk);

        finish_run();
    end

endmodule